// File: doc/BRIEF.md
# Palette RAMDAC Host Register Interface

This block is the processor-facing register file of a colour palette RAMDAC. A host reaches it through an 8-bit data bus, a two-bit target select, a write strobe and a read strobe. The select chooses one of four targets: an 8-bit address pointer, the palette data port, a small bank of control registers reached indirectly through the address pointer, or the mode register. The palette has 256 entries. Each entry holds three 8-bit colour components.

The palette is loaded one component at a time, in red, green, blue order. After the blue byte, the address pointer moves to the next entry on its own, so the host can fill the whole table with one address write followed by a stream of data writes. Reads follow the same order and advance the pointer in the same way.

Two detectors watch consecutive mode-register writes and emit one-cycle pulses. The first pulse resets the pixel pipelines. The second pulse synchronises the load-clock timing. Each pulse fires when its watched mode bit shows a fixed three-value pattern across three mode writes in a row.

Top module: `palette_host_if`

## Requirements
- R1: While rst_ni is low, data_o, mode_o, pix_mask_o, cmd1_o, cmd2_o, cmd3_o, pipe_rst_o and load_sync_o are all 0, and the address pointer and component pointer return to 0 and red. Palette contents are not cleared.
- R2: A write with sel_i=00 loads data_i into the address pointer. A read with sel_i=00 returns the address pointer.
- R3: A write with sel_i=11 stores data_i into the mode register, which appears on mode_o after that clock edge. A read with sel_i=11 returns it.
- R4: With sel_i=10, the address pointer picks an indirect register: 04h is the pixel mask, 05h control register 1, 06h control register 2 and 07h control register 3. A write stores data_i and a read returns the stored value. At any other address, writes are ignored and reads return 00h.
- R5: Three successive sel_i=01 writes store red, green and blue of the entry at the address pointer.
- R6: The access that handles blue moves the address pointer up by one, wrapping from FFh to 00h, and the next access is red again.
- R7: A write to the address pointer resets the component pointer to red.
- R8: Reads with sel_i=01 return red, green and blue of the current entry in that order, with the same advance as writes.
- R9: Mode writes whose bit 0 takes the values 1, 0, 1 on three consecutive mode writes raise pipe_rst_o for exactly the one cycle after the third write.
- R10: Mode writes whose bit 5 takes the values 0, 1, 0 on three consecutive mode writes raise load_sync_o for exactly the one cycle after the third write.
- R11: A mode write that breaks a pattern restarts that detector, and the breaking write counts as a new first step if it matches. Accesses to other targets do not affect either detector.
- R12: data_o is registered. It changes only on a clock edge with rd_i high and wr_i low, and otherwise holds. When wr_i and rd_i are both high, the access is a write only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Target select: 00 address, 01 palette, 10 indirect, 11 mode |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe, one access per cycle |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Registered read data |
| mode_o | output | 8 | Mode register |
| pix_mask_o | output | 8 | Pixel mask register |
| cmd1_o | output | 8 | Control register 1 |
| cmd2_o | output | 8 | Control register 2 |
| cmd3_o | output | 8 | Control register 3 |
| pipe_rst_o | output | 1 | One-cycle pixel pipeline reset pulse |
| load_sync_o | output | 1 | One-cycle load timing synchronisation pulse |

## Verification
The palette port is exercised in four ways:
- Full triplets read back after a fresh address write show that the components land in the right order.
- An incomplete triplet followed by an address rewrite shows that the component pointer restarts at red.
- A triplet written at FFh shows the wrap to 00h.
- Interleaved reads of the address pointer show exactly when the auto-increment happens.

The detectors are driven with several mode-write streams:
- The exact trigger sequences.
- A sequence with a repeated first step.
- A sequence that breaks in the middle.
- A sequence with writes to other targets mixed in.

Together these separate a correct restart rule from one that clears too eagerly or counts writes that are not mode writes.

// File: rtl/palette_host_pkg.sv
package palette_host_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'b00,
    SEL_PAL  = 2'b01,
    SEL_IND  = 2'b10,
    SEL_MODE = 2'b11
  } host_sel_e;

  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;

  localparam int unsigned NUM_COMP = 3;
endpackage

// File: rtl/palette_ptr.sv
module palette_ptr
  import palette_host_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output comp_e         comp_o
);
  logic [AW-1:0] addr_q;
  comp_e         comp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      comp_q <= COMP_R;
    end else if (load_i) begin
      addr_q <= load_val_i;
      comp_q <= COMP_R;
    end else if (step_i) begin
      unique case (comp_q)
        COMP_R:  comp_q <= COMP_G;
        COMP_G:  comp_q <= COMP_B;
        default: begin
          comp_q <= COMP_R;
          addr_q <= addr_q + 1'b1; // natural wrap
        end
      endcase
    end
  end

  assign addr_o = addr_q;
  assign comp_o = comp_q;
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_host_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  comp_e         comp_i,
  input  logic [CW-1:0] data_i,
  output logic [CW-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [CW-1:0] comp_rd [NUM_COMP];

  // one plane per colour component
  for (genvar g = 0; g < NUM_COMP; g++) begin : g_plane
    logic [CW-1:0] plane_mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_i && (comp_i == comp_e'(g)))
        plane_mem[addr_i] <= data_i;
    end
    assign comp_rd[g] = plane_mem[addr_i];
  end

  always_comb begin
    unique case (comp_i)
      COMP_R:  rd_data_o = comp_rd[0];
      COMP_G:  rd_data_o = comp_rd[1];
      default: rd_data_o = comp_rd[2];
    endcase
  end
endmodule

// File: rtl/ind_regs.sv
module ind_regs #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned BASE  = 4,
  parameter int unsigned NREG  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] regs_o [NREG]
);
  logic [NREG-1:0] hit;
  logic [DW-1:0]   reg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [AW-1:0] IDX = AW'(BASE + g);
    assign hit[g] = (idx_i == IDX);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             reg_q[g] <= '0;
      else if (wr_i && hit[g]) reg_q[g] <= data_i;
    end
    assign regs_o[g] = reg_q[g];
  end

  always_comb begin
    rd_data_o = '0; // unmapped index reads zero
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rd_data_o = reg_q[i];
  end
endmodule

// File: rtl/toggle_detect.sv
module toggle_detect #(
  parameter int unsigned DW      = 8,
  parameter int unsigned BIT     = 0,
  parameter logic [2:0]  PATTERN = 3'b101 // [2] first value
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic          pulse_o
);
  logic [1:0] stage_q;
  logic       bit_v;
  logic       want;

  assign bit_v = data_i[BIT];

  always_comb begin
    unique case (stage_q)
      2'd0:    want = PATTERN[2];
      2'd1:    want = PATTERN[1];
      default: want = PATTERN[0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'd0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (wr_i) begin
        if (bit_v == want) begin
          if (stage_q == 2'd2) begin
            stage_q <= 2'd0;
            pulse_o <= 1'b1;
          end else begin
            stage_q <= stage_q + 2'd1;
          end
        end else begin
          // restart; breaking write may open a new sequence
          stage_q <= (bit_v == PATTERN[2]) ? 2'd1 : 2'd0;
        end
      end
    end
  end
endmodule

// File: rtl/palette_host_if.sv
module palette_host_if
  import palette_host_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned IND_BASE = 4,
  parameter int unsigned PIPE_BIT = 0,
  parameter int unsigned SYNC_BIT = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] pix_mask_o,
  output logic [DW-1:0] cmd1_o,
  output logic [DW-1:0] cmd2_o,
  output logic [DW-1:0] cmd3_o,
  output logic          pipe_rst_o,
  output logic          load_sync_o
);
  localparam int unsigned AW   = DW;
  localparam int unsigned NREG = 4;

  host_sel_e     sel;
  logic          wr_en, rd_en;
  logic [AW-1:0] addr_w;
  comp_e         comp_w;
  logic [DW-1:0] pal_rd, ind_rd;
  logic [DW-1:0] ind_q [NREG];
  logic [DW-1:0] mode_q;
  logic          mode_wr;

  assign sel     = host_sel_e'(sel_i);
  assign wr_en   = wr_i;
  assign rd_en   = rd_i & ~wr_i;
  assign mode_wr = wr_en && (sel == SEL_MODE);

  palette_ptr #(.AW(AW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_en && (sel == SEL_ADDR)),
    .load_val_i (data_i),
    .step_i     ((wr_en || rd_en) && (sel == SEL_PAL)),
    .addr_o     (addr_w),
    .comp_o     (comp_w)
  );

  palette_store #(.AW(AW), .CW(DW)) u_store (
    .clk_i     (clk_i),
    .wr_i      (wr_en && (sel == SEL_PAL)),
    .addr_i    (addr_w),
    .comp_i    (comp_w),
    .data_i    (data_i),
    .rd_data_o (pal_rd)
  );

  ind_regs #(.AW(AW), .DW(DW), .BASE(IND_BASE), .NREG(NREG)) u_ind (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en && (sel == SEL_IND)),
    .idx_i     (addr_w),
    .data_i    (data_i),
    .rd_data_o (ind_rd),
    .regs_o    (ind_q)
  );

  toggle_detect #(.DW(DW), .BIT(PIPE_BIT), .PATTERN(3'b101)) u_pipe_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (mode_wr),
    .data_i  (data_i),
    .pulse_o (pipe_rst_o)
  );

  toggle_detect #(.DW(DW), .BIT(SYNC_BIT), .PATTERN(3'b010)) u_sync_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (mode_wr),
    .data_i  (data_i),
    .pulse_o (load_sync_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (mode_wr) mode_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
    end else if (rd_en) begin
      unique case (sel)
        SEL_ADDR: data_o <= addr_w;
        SEL_PAL:  data_o <= pal_rd;
        SEL_IND:  data_o <= ind_rd;
        default:  data_o <= mode_q;
      endcase
    end
  end

  assign mode_o     = mode_q;
  assign pix_mask_o = ind_q[0];
  assign cmd1_o     = ind_q[1];
  assign cmd2_o     = ind_q[2];
  assign cmd3_o     = ind_q[3];
endmodule

// File: rtl/palette_host_chk.sv
module palette_host_chk #(
  parameter int unsigned DW       = 8,
  parameter int unsigned IND_BASE = 4,
  parameter int unsigned PIPE_BIT = 0,
  parameter int unsigned SYNC_BIT = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    sel_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [DW-1:0] data_i,
  input logic [DW-1:0] data_o,
  input logic [DW-1:0] mode_o,
  input logic [DW-1:0] pix_mask_o,
  input logic          pipe_rst_o,
  input logic          load_sync_o,
  input logic [DW-1:0] addr_q
);
  localparam logic [DW-1:0] MASK_IDX = DW'(IND_BASE);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni)
      a_r1_reset_clear: assert (data_o == '0 && mode_o == '0 && !pipe_rst_o && !load_sync_o);
  end

  a_r3_mode_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 2'b11) |=> (mode_o == $past(data_i)));

  a_r4_mask_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 2'b10 && addr_q == MASK_IDX) |=> (pix_mask_o == $past(data_i)));

  a_r9_pipe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_rst_o |=> !pipe_rst_o);

  a_r9_pipe_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_rst_o |-> $past(wr_i && sel_i == 2'b11 && data_i[PIPE_BIT]));

  a_r10_sync_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_sync_o |=> !load_sync_o);

  a_r10_sync_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_sync_o |-> $past(wr_i && sel_i == 2'b11 && !data_i[SYNC_BIT]));

  a_r12_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i || wr_i) |=> $stable(data_o));
endmodule

bind palette_host_if palette_host_chk #(
  .DW(DW), .IND_BASE(IND_BASE), .PIPE_BIT(PIPE_BIT), .SYNC_BIT(SYNC_BIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .data_i      (data_i),
  .data_o      (data_o),
  .mode_o      (mode_o),
  .pix_mask_o  (pix_mask_o),
  .pipe_rst_o  (pipe_rst_o),
  .load_sync_o (load_sync_o),
  .addr_q      (addr_w)
);

// File: tb/tb_palette_host_if.sv
module tb_palette_host_if;
  localparam int CLK_P = 10;
  localparam int NV    = 28;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, mode, mask, c1, c2, c3;
  logic       prst, lsync;
  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  palette_host_if dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .data_i(din), .data_o(dout), .mode_o(mode), .pix_mask_o(mask),
    .cmd1_o(c1), .cmd2_o(c2), .cmd3_o(c3),
    .pipe_rst_o(prst), .load_sync_o(lsync)
  );

  // {is_read, sel, data, expected, requirement}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 2'b00, 8'h10, 8'h00, 4'd2},  // R2 address load
    {1'b1, 2'b00, 8'h00, 8'h10, 4'd2},
    {1'b0, 2'b01, 8'h11, 8'h00, 4'd5},  // R5 triplet
    {1'b0, 2'b01, 8'h22, 8'h00, 4'd5},
    {1'b0, 2'b01, 8'h33, 8'h00, 4'd5},
    {1'b1, 2'b00, 8'h00, 8'h11, 4'd6},  // R6 advanced after blue
    {1'b0, 2'b00, 8'h10, 8'h00, 4'd2},
    {1'b1, 2'b01, 8'h00, 8'h11, 4'd8},  // R8 read order
    {1'b1, 2'b01, 8'h00, 8'h22, 4'd8},
    {1'b1, 2'b01, 8'h00, 8'h33, 4'd8},
    {1'b1, 2'b00, 8'h00, 8'h11, 4'd8},
    {1'b0, 2'b00, 8'h04, 8'h00, 4'd4},  // R4 indirect
    {1'b0, 2'b10, 8'hFF, 8'h00, 4'd4},
    {1'b1, 2'b10, 8'h00, 8'hFF, 4'd4},
    {1'b0, 2'b00, 8'h05, 8'h00, 4'd4},
    {1'b0, 2'b10, 8'hA5, 8'h00, 4'd4},
    {1'b1, 2'b10, 8'h00, 8'hA5, 4'd4},
    {1'b0, 2'b00, 8'h06, 8'h00, 4'd4},
    {1'b0, 2'b10, 8'hEC, 8'h00, 4'd4},
    {1'b1, 2'b10, 8'h00, 8'hEC, 4'd4},
    {1'b0, 2'b00, 8'h07, 8'h00, 4'd4},
    {1'b0, 2'b10, 8'h40, 8'h00, 4'd4},
    {1'b1, 2'b10, 8'h00, 8'h40, 4'd4},
    {1'b0, 2'b00, 8'h09, 8'h00, 4'd4},
    {1'b0, 2'b10, 8'h77, 8'h00, 4'd4},
    {1'b1, 2'b10, 8'h00, 8'h00, 4'd4},  // unmapped reads zero
    {1'b0, 2'b11, 8'hC3, 8'h00, 4'd3},  // R3 mode
    {1'b1, 2'b11, 8'h00, 8'hC3, 4'd3}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive after negedge, capture at posedge, return at next negedge
  task automatic wr_op(input logic [1:0] s, input logic [7:0] d);
    sel = s; din = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_op(input logic [1:0] s, output logic [7:0] q);
    sel = s; rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; q = dout;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic mode_seq(input string req, input logic [7:0] d, input logic ep, input logic es);
    wr_op(2'b11, d);
    chk(req, {7'd0, prst}, {7'd0, ep});
    chk(req, {7'd0, lsync}, {7'd0, es});
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] q;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 data_o", dout, 8'h00);
    chk("R1 mode_o", mode, 8'h00);
    chk("R1 mask", mask, 8'h00);
    chk("R1 pulses", {6'd0, prst, lsync}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][22]) begin
        rd_op(VEC[i][21:20], q);
        chk($sformatf("R%0d vec%0d", VEC[i][3:0], i), q, VEC[i][11:4]);
      end else begin
        wr_op(VEC[i][21:20], VEC[i][19:12]);
      end
    end
    chk("R4 pix_mask_o", mask, 8'hFF);
    chk("R4 cmd1_o", c1, 8'hA5);
    chk("R4 cmd2_o", c2, 8'hEC);
    chk("R4 cmd3_o", c3, 8'h40);
    chk("R3 mode_o", mode, 8'hC3);

    // R12 hold and write priority
    rd_op(2'b11, q);
    wr_op(2'b00, 8'h55);
    chk("R12 hold on write", dout, 8'hC3);
    sel = 2'b11; din = 8'h5A; wr = 1'b1; rd = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    chk("R12 write wins data_o", dout, 8'hC3);
    chk("R12 write wins mode_o", mode, 8'h5A);

    // R6 wrap at FFh
    wr_op(2'b00, 8'hFF);
    wr_op(2'b01, 8'h01); wr_op(2'b01, 8'h02); wr_op(2'b01, 8'h03);
    rd_op(2'b00, q); chk("R6 wrap addr", q, 8'h00);
    wr_op(2'b01, 8'h04); wr_op(2'b01, 8'h05); wr_op(2'b01, 8'h06);
    wr_op(2'b00, 8'hFF);
    rd_op(2'b01, q); chk("R8 FF red", q, 8'h01);
    rd_op(2'b01, q); chk("R8 FF green", q, 8'h02);
    rd_op(2'b01, q); chk("R8 FF blue", q, 8'h03);
    rd_op(2'b01, q); chk("R6 00 red", q, 8'h04);
    rd_op(2'b01, q); chk("R6 00 green", q, 8'h05);
    rd_op(2'b01, q); chk("R6 00 blue", q, 8'h06);
    rd_op(2'b00, q); chk("R6 addr after", q, 8'h01);

    // R7 address write restarts at red
    wr_op(2'b00, 8'h20);
    wr_op(2'b01, 8'hAA);
    wr_op(2'b00, 8'h20);
    wr_op(2'b01, 8'h41); wr_op(2'b01, 8'h42); wr_op(2'b01, 8'h43);
    wr_op(2'b00, 8'h20);
    rd_op(2'b01, q); chk("R7 red", q, 8'h41);
    rd_op(2'b01, q); chk("R7 green", q, 8'h42);
    rd_op(2'b01, q); chk("R7 blue", q, 8'h43);

    // R1 reset clears registers, keeps palette
    do_reset();
    chk("R1 mask after reset", mask, 8'h00);
    chk("R1 mode after reset", mode, 8'h00);
    rd_op(2'b00, q); chk("R1 addr after reset", q, 8'h00);
    rd_op(2'b01, q); chk("R1 palette kept", q, 8'h04);

    // R9 / R10 trigger sequences
    do_reset();
    mode_seq("R9/R10 w1", 8'h09, 1'b0, 1'b0);
    mode_seq("R9/R10 w2", 8'h08, 1'b0, 1'b0);
    mode_seq("R9 w3", 8'h09, 1'b1, 1'b0);
    mode_seq("R10 w4", 8'h29, 1'b0, 1'b0);
    mode_seq("R10 w5", 8'h09, 1'b0, 1'b1);
    @(negedge clk);
    chk("R9 pulse one cycle", {7'd0, prst}, 8'h00);

    // R11 restart rules
    do_reset();
    mode_seq("R11 a1", 8'h01, 1'b0, 1'b0);
    mode_seq("R11 a2", 8'h01, 1'b0, 1'b0);
    mode_seq("R11 a3", 8'h00, 1'b0, 1'b0);
    mode_seq("R11 a4 repeated first", 8'h01, 1'b1, 1'b0);
    mode_seq("R11 b1", 8'h01, 1'b0, 1'b0);
    mode_seq("R11 b2", 8'h00, 1'b0, 1'b0);
    mode_seq("R11 b3", 8'h00, 1'b0, 1'b0);
    mode_seq("R11 b4 broken", 8'h01, 1'b0, 1'b0);
    do_reset();
    mode_seq("R11 c1", 8'h01, 1'b0, 1'b0);
    mode_seq("R11 c2", 8'h00, 1'b0, 1'b0);
    wr_op(2'b00, 8'h33);
    wr_op(2'b10, 8'h20);
    mode_seq("R11 c3 interleaved", 8'h01, 1'b1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule